// File: doc/BRIEF.md
# Pushbutton Power Sequencing Controller

This block is the power-state controller of a portable device. It watches one active-low pushbutton, a hold-up request that the host drives high once it has booted, and an undervoltage flag. From these it decides when the main supplies come up, when they stay up and when they go down. A short press from either off state starts power-up. The three switching regulators are then enabled one after another. A fixed hold-up window gives the host time to assert its hold-up request. A long press that began while the device was powered forces a hard reset into the deepest off state.

Every duration is counted in pulses of a `tick` input, for example one per millisecond, and each count is a parameter. The controller has seven states:

- a deep shipping state entered after reset,
- a normal off state,
- two power-up states, one entered from each off state, which behave the same,
- the on state,
- a soft power-down state and a hard power-down state.

Both power-down states hold for a fixed time before they may be left. In the shipping state only a periodic sensor-sample strobe stays active. The auxiliary supplies are not switched here. The block only raises a flag saying when the bus may enable them, and it sends a clear pulse that drops them on entry to power-down.

Top module: `pb_power_seq`

## Requirements
- R1: After reset the controller is in the shipping state. `wake`, `rail_en`, `aux_allow`, `reg_clear` and `sample_stb` are all 0, and `btn_stat_n` is 1.
- R2: A button press (`btn_n` = 0) held for T_START ticks, while in the shipping or off state, enters a power-up state. `wake` and `aux_allow` go to 1, and `rail_en` bit 0 turns on.
- R3: `rail_en` bit i turns on i*T_STAGGER ticks after power-up begins, so the bits come on in ascending order. Bit i is never on while bit i-1 is off.
- R4: T_HOLDUP ticks after entering power-up, the controller moves to the on state if `hold_req` is 1. If `hold_req` is 0 it enters soft power-down, and all `rail_en` bits drop in the same cycle.
- R5: In the on state, `hold_req` = 0 or `uv_flag` = 1 sends the controller to soft power-down.
- R6: Each entry into either power-down state raises `reg_clear` for exactly one clock. `wake`, `rail_en` and `aux_allow` are 0 there, and the state holds for T_DOWN ticks. Soft power-down then goes to the off state and hard power-down to the shipping state.
- R7: A press held for T_HARD ticks that began in a power-up or on state is a hard-reset event. The event sends the on, soft power-down or off state to hard power-down, even when the press has outlived the powered states.
- R8: A press that began in the shipping or off state never produces a hard-reset event, however long it is held.
- R9: `btn_stat_n` is 0 only while the button is pressed, the press began in a power-up or on state, and the controller is still in one of those states. It stays 1 during the press that powers the device up.
- R10: `aux_allow` is 1 exactly in the power-up and on states.
- R11: In the shipping state, `sample_stb` pulses for one clock every T_SAMPLE ticks. It never pulses in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock time-base pulse used by every duration counter |
| btn_n | input | 1 | Pushbutton, active low, asynchronous |
| hold_req | input | 1 | Host request to keep the supplies on |
| uv_flag | input | 1 | Output-voltage undervoltage indication |
| wake | output | 1 | Main power enable, high in power-up and on states |
| rail_en | output | N_RAILS | Staggered regulator enables, bit 0 first |
| reg_clear | output | 1 | One-clock pulse on entry to power-down |
| btn_stat_n | output | 1 | Debounced button status, active low, powered presses only |
| aux_allow | output | 1 | Permission for bus-controlled auxiliary supplies |
| sample_stb | output | 1 | Periodic sensor-sample strobe in the shipping state |

## Verification
Every cycle, the assertions check four things:
- the regulator enables keep their ascending order;
- the enables never outlive `wake`;
- the clear pulse is a single clock wide;
- the sample strobe fires only in the shipping state, and a lost hold-up request in the on state always leads to soft power-down.

Only the scenarios can show the timing and the origin rules. These are the hold-up window length, the power-down hold time, and that a long press is qualified by where it started rather than where it ends. They also cover the status output staying quiet during the powering press and the strobe period.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    typedef enum logic [2:0] {
        ST_SHIP      = 3'd0,
        ST_OFF       = 3'd1,
        ST_RISE_A    = 3'd2,
        ST_RISE_B    = 3'd3,
        ST_ON        = 3'd4,
        ST_DROP_HARD = 3'd5,
        ST_DROP_SOFT = 3'd6
    } pstate_t;

    typedef struct packed {
        logic pressed;    // synchronized button is held
        logic qualified;  // current press began in a powered state
        logic start_evt;  // press reached power-up length on this tick
        logic hard_evt;   // qualified press reached hard-reset length
    } press_t;

    function automatic logic is_rising(pstate_t s);
        return (s == ST_RISE_A) || (s == ST_RISE_B);
    endfunction

    function automatic logic is_powered(pstate_t s);
        return is_rising(s) || (s == ST_ON);
    endfunction

    function automatic logic is_down(pstate_t s);
        return (s == ST_DROP_HARD) || (s == ST_DROP_SOFT);
    endfunction

    function automatic int unsigned cnt_width(int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pbseq_sync.sv
module pbseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pbseq_press.sv
module pbseq_press
    import pbseq_pkg::*;
#(
    parameter int T_START = 400,
    parameter int T_HARD  = 5000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   pressed,
    input  logic   powered,
    output press_t pr
);
    localparam int PW = cnt_width(T_HARD);
    localparam logic [PW-1:0] START_LAST = PW'(T_START - 1);
    localparam logic [PW-1:0] HARD_LAST  = PW'(T_HARD - 1);
    localparam logic [PW-1:0] CNT_SAT    = PW'(T_HARD);

    logic [PW-1:0] cnt_q;
    logic          pressed_q;
    logic          qual_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            pressed_q <= 1'b0;
            qual_q    <= 1'b0;
        end else begin
            pressed_q <= pressed;
            if (!pressed) begin
                cnt_q  <= '0;
                qual_q <= 1'b0;
            end else begin
                if (!pressed_q) qual_q <= powered;
                if (tick && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        pr.pressed   = pressed;
        pr.qualified = qual_q;
        pr.start_evt = pressed && tick && (cnt_q == START_LAST);
        pr.hard_evt  = pressed && qual_q && tick && (cnt_q == HARD_LAST);
    end

    // R8: a hard-reset event needs a press that was already running a cycle ago
    a_r8_hard_on_running_press: assert property (@(posedge clk) disable iff (rst)
        pr.hard_evt |-> pressed_q);
endmodule

// File: rtl/pbseq_rails.sv
module pbseq_rails
    import pbseq_pkg::*;
#(
    parameter int N_RAILS   = 3,
    parameter int T_STAGGER = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               on,
    output logic [N_RAILS-1:0] rail_en
);
    localparam int SPAN = (N_RAILS - 1) * T_STAGGER;
    localparam int SW   = cnt_width(SPAN);
    localparam logic [SW-1:0] STEP_SAT = SW'(SPAN);

    logic [SW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || !on)                  step_q <= '0;
        else if (tick && step_q != STEP_SAT) step_q <= step_q + 1'b1;
    end

    for (genvar gi = 0; gi < N_RAILS; gi++) begin : g_rail
        always_ff @(posedge clk) begin
            if (rst) rail_en[gi] <= 1'b0;
            else     rail_en[gi] <= on && (step_q >= SW'(gi * T_STAGGER));
        end
        if (gi > 0) begin : g_order
            // R3: a rail comes up only after its predecessor is already on
            a_r3_rail_order: assert property (@(posedge clk) disable iff (rst)
                $rose(rail_en[gi]) |-> (rail_en[gi-1] && !$rose(rail_en[gi-1])));
        end
    end
endmodule

// File: rtl/pbseq_sampler.sv
module pbseq_sampler
    import pbseq_pkg::*;
#(
    parameter int T_SAMPLE = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    output logic stb
);
    localparam int SW = cnt_width(T_SAMPLE);
    localparam logic [SW-1:0] LAST = SW'(T_SAMPLE - 1);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= tick && (cnt_q == LAST);
            if (tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pb_power_seq.sv
module pb_power_seq
    import pbseq_pkg::*;
#(
    parameter int N_RAILS   = 3,
    parameter int T_START   = 400,
    parameter int T_HARD    = 5000,
    parameter int T_HOLDUP  = 5000,
    parameter int T_DOWN    = 1000,
    parameter int T_STAGGER = 20,
    parameter int T_SAMPLE  = 150
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               btn_n,
    input  logic               hold_req,
    input  logic               uv_flag,
    output logic               wake,
    output logic [N_RAILS-1:0] rail_en,
    output logic               reg_clear,
    output logic               btn_stat_n,
    output logic               aux_allow,
    output logic               sample_stb
);
    localparam int TMAX = (T_HOLDUP > T_DOWN) ? T_HOLDUP : T_DOWN;
    localparam int TW   = cnt_width(TMAX);
    localparam logic [TW-1:0] HOLD_LAST = TW'(T_HOLDUP - 1);
    localparam logic [TW-1:0] DOWN_LAST = TW'(T_DOWN - 1);
    localparam logic [TW-1:0] TMR_SAT   = TW'(TMAX);

    pstate_t       st_q, st_n;
    logic [TW-1:0] tmr_q;
    logic          btn_s;
    press_t        pr;

    pbseq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(btn_n), .q(btn_s)
    );

    pbseq_press #(.T_START(T_START), .T_HARD(T_HARD)) u_press (
        .clk(clk), .rst(rst), .tick(tick), .pressed(!btn_s),
        .powered(is_powered(st_q)), .pr(pr)
    );

    // next-state decode; hard reset outranks every other exit
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_SHIP:      if (pr.start_evt) st_n = ST_RISE_A;
            ST_OFF: begin
                if (pr.hard_evt)       st_n = ST_DROP_HARD;
                else if (pr.start_evt) st_n = ST_RISE_B;
            end
            ST_RISE_A,
            ST_RISE_B:    if (tick && tmr_q == HOLD_LAST)
                              st_n = hold_req ? ST_ON : ST_DROP_SOFT;
            ST_ON: begin
                if (pr.hard_evt)                st_n = ST_DROP_HARD;
                else if (!hold_req || uv_flag)  st_n = ST_DROP_SOFT;
            end
            ST_DROP_SOFT: begin
                if (pr.hard_evt)                      st_n = ST_DROP_HARD;
                else if (tick && tmr_q == DOWN_LAST)  st_n = ST_OFF;
            end
            ST_DROP_HARD: if (tick && tmr_q == DOWN_LAST) st_n = ST_SHIP;
            default:      st_n = ST_SHIP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_SHIP;
            tmr_q     <= '0;
            reg_clear <= 1'b0;
        end else begin
            st_q      <= st_n;
            reg_clear <= (st_n != st_q) && is_down(st_n);
            if (st_n != st_q)                  tmr_q <= '0;
            else if (tick && tmr_q != TMR_SAT) tmr_q <= tmr_q + 1'b1;
        end
    end

    assign wake       = is_powered(st_q);
    assign aux_allow  = is_powered(st_q);
    assign btn_stat_n = !(pr.pressed && pr.qualified && is_powered(st_q));

    pbseq_rails #(.N_RAILS(N_RAILS), .T_STAGGER(T_STAGGER)) u_rails (
        .clk(clk), .rst(rst), .tick(tick), .on(wake), .rail_en(rail_en)
    );

    pbseq_sampler #(.T_SAMPLE(T_SAMPLE)) u_sampler (
        .clk(clk), .rst(rst), .tick(tick), .en(st_q == ST_SHIP), .stb(sample_stb)
    );

    // R6: the clear pulse is exactly one clock wide
    a_r6_clear_single: assert property (@(posedge clk) disable iff (rst)
        reg_clear |=> !reg_clear);

    // R6: power-down leaves no regulator enabled
    a_r6_down_rails_off: assert property (@(posedge clk) disable iff (rst)
        is_down(st_q) |=> (rail_en == '0));

    // R4: regulator enables never outlive the wake enable
    a_r4_rails_follow_wake: assert property (@(posedge clk) disable iff (rst)
        (rail_en != '0) |-> $past(wake));

    // R5: lost hold-up request in the on state leads to soft power-down
    a_r5_on_loss_drops: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ON && !hold_req && !pr.hard_evt) |=> (st_q == ST_DROP_SOFT));

    // R11: the sample strobe only follows a cycle spent in the shipping state
    a_r11_stb_in_ship: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> $past(st_q == ST_SHIP));
endmodule

// File: tb/pb_power_seq_bench.sv
module pb_power_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 3;
    localparam int NVEC = 16;

    // vector: [12] btn_n [11] hold_req [10] uv_flag [9:6] ticks
    //         [5] wake [4:2] rail_en [1] aux_allow [0] btn_stat_n
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1,1'b0,1'b0,4'd2, 1'b0,3'b000,1'b0,1'b1}, // idle in ship
        {1'b0,1'b0,1'b0,4'd2, 1'b0,3'b000,1'b0,1'b1}, // press too short yet
        {1'b0,1'b0,1'b0,4'd1, 1'b1,3'b001,1'b1,1'b1}, // R2 power-up, R9 quiet
        {1'b1,1'b0,1'b0,4'd2, 1'b1,3'b011,1'b1,1'b1}, // R3 second rail
        {1'b1,1'b1,1'b0,4'd2, 1'b1,3'b111,1'b1,1'b1}, // R3 third rail
        {1'b0,1'b1,1'b0,4'd1, 1'b1,3'b111,1'b1,1'b0}, // R9 powered press
        {1'b1,1'b1,1'b0,4'd3, 1'b1,3'b111,1'b1,1'b1}, // R4 into on state
        {1'b1,1'b0,1'b0,4'd0, 1'b0,3'b000,1'b0,1'b1}, // R5 hold lost
        {1'b1,1'b0,1'b0,4'd4, 1'b0,3'b000,1'b0,1'b1}, // R6 into off
        {1'b0,1'b0,1'b0,4'd3, 1'b1,3'b001,1'b1,1'b1}, // R2 from off
        {1'b1,1'b0,1'b0,4'd8, 1'b0,3'b000,1'b0,1'b1}, // R4 timeout drops
        {1'b1,1'b0,1'b0,4'd4, 1'b0,3'b000,1'b0,1'b1}, // R6 back to off
        {1'b0,1'b1,1'b0,4'd3, 1'b1,3'b001,1'b1,1'b1}, // R2 again
        {1'b1,1'b1,1'b0,4'd8, 1'b1,3'b111,1'b1,1'b1}, // R4 kept on
        {1'b1,1'b1,1'b1,4'd0, 1'b0,3'b000,1'b0,1'b1}, // R5 undervoltage
        {1'b1,1'b1,1'b0,4'd4, 1'b0,3'b000,1'b0,1'b1}  // R6 off again
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic btn_n = 1'b1;
    logic hold_req = 1'b0;
    logic uv_flag = 1'b0;
    logic wake, reg_clear, btn_stat_n, aux_allow, sample_stb;
    logic [NR-1:0] rail_en;

    int n_chk = 0;
    int n_fail = 0;
    int clr_cnt = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pb_power_seq #(
        .N_RAILS(NR), .T_START(3), .T_HARD(12), .T_HOLDUP(8),
        .T_DOWN(4), .T_STAGGER(2), .T_SAMPLE(5)
    ) u_pb_power_seq (
        .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n), .hold_req(hold_req),
        .uv_flag(uv_flag), .wake(wake), .rail_en(rail_en), .reg_clear(reg_clear),
        .btn_stat_n(btn_stat_n), .aux_allow(aux_allow), .sample_stb(sample_stb)
    );

    always @(negedge clk) begin
        if (reg_clear)  clr_cnt++;
        if (sample_stb) stb_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {27'd0, wake, rail_en, aux_allow},  32'd0);
        chk("R1 btn_stat_n", {31'd0, btn_stat_n}, 32'd1);
        chk("R1 reg_clear", {31'd0, reg_clear}, 32'd0);

        // table walk: R2 R3 R4 R5 R6 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            btn_n = VEC[v][12]; hold_req = VEC[v][11]; uv_flag = VEC[v][10];
            settle();
            do_ticks(int'(VEC[v][9:6]));
            chk($sformatf("R2-table vec %0d wake/rails/R10 aux/R9 stat", v),
                {26'd0, wake, rail_en, aux_allow, btn_stat_n}, {26'd0, VEC[v][5:0]});
        end

        // R11 no strobe outside ship (now in off state)
        stb_cnt = 0;
        do_ticks(10);
        chk("R11 no strobe in off", stb_cnt, 0);

        // R7 hard reset from on state, R6 clear pulse
        hold_req = 1'b1; btn_n = 1'b0; settle();
        do_ticks(3);
        btn_n = 1'b1; settle();
        do_ticks(8);
        chk("R4 on before hard press", {28'd0, wake, rail_en}, 32'hF);
        btn_n = 1'b0; settle();
        clr_cnt = 0;
        do_ticks(11);
        chk("R7 not early", {31'd0, wake}, 32'd1);
        do_ticks(1);
        chk("R7 hard down outputs", {27'd0, wake, rail_en, aux_allow}, 32'd0);
        chk("R6 one clear pulse", clr_cnt, 1);
        btn_n = 1'b1; settle();
        do_ticks(3);
        stb_cnt = 0;
        do_ticks(1);
        do_ticks(10);
        chk("R11 strobe period in ship", stb_cnt, 2);

        // R8 long press from ship never hard-resets; R9 quiet status
        clr_cnt = 0;
        btn_n = 1'b0; settle();
        do_ticks(14);
        chk("R8 still powered", {31'd0, wake}, 32'd1);
        chk("R8 no clear", clr_cnt, 0);
        chk("R9 quiet on powering press", {31'd0, btn_stat_n}, 32'd1);
        btn_n = 1'b1; settle();

        // R7 press begun in on state ends in off state
        btn_n = 1'b0; settle();
        chk("R9 status in on", {31'd0, btn_stat_n}, 32'd0);
        clr_cnt = 0;
        hold_req = 1'b0; settle();
        chk("R9 status released in down", {31'd0, btn_stat_n}, 32'd1);
        do_ticks(4);
        chk("R6 soft down reached off", {28'd0, wake, rail_en}, 32'd0);
        do_ticks(8);
        chk("R7 hard event late clear", clr_cnt, 2);
        btn_n = 1'b1; settle();
        do_ticks(4);
        stb_cnt = 0;
        do_ticks(5);
        chk("R7 reached ship", stb_cnt, 1);

        // R1 reset while powered
        hold_req = 1'b1; btn_n = 1'b0; settle();
        do_ticks(3);
        btn_n = 1'b1; settle();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run", {27'd0, wake, rail_en, aux_allow}, 32'd0);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule